// File: doc/BRIEF.md
# Programmable Delay and Pulse-Width Generator

This block is a clocked model of an 8-bit programmable timing element. A one-bit input is sampled on every rising clock edge. One programmed step is one clock cycle. The input runs down a shift register, and an 8-bit step code picks the tap that drives the main output. A fixed tap of `ZERO_STEPS` stages drives a reference output. That tap is the zero-step delay, and the main output is measured against it. So the main output can be placed anywhere from zero to 255 steps after the reference, which covers a full input period or more.

Every sampled input value stays in the register. Any number of edges can therefore be in flight, and a delay may be much longer than the input high or low time.

A mode bit changes the output behaviour. When it is set, the main output is the inverted delayed input, and a third output gives a pulse. The pulse starts together with each rising edge of the reference output and stays high for the programmed number of steps. If the main output is wired back to the input in this mode, the block runs as a free oscillator whose period is set by the code. The step code and the mode bit are captured on each clock edge and take effect right after that edge.

Top module: `prog_timing_elem`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `main_o`, `ref_o` and `pulse_o` are 0. The active code and the mode are cleared to 0.
- R2: `dly_code_i` and `inv_mode_i` are captured on every rising edge. The outputs seen after edge n use the values that were applied before edge n. A code change therefore moves the main tap on that same edge.
- R3: With the mode at 0 and code c, `main_o` after edge n equals `sig_i` as sampled at edge n-ZERO_STEPS-c, with the same polarity. ZERO_STEPS defaults to 2. With c = 0, `main_o` equals `ref_o`.
- R4: In both modes, `ref_o` after edge n equals `sig_i` as sampled at edge n-ZERO_STEPS.
- R5: Rising and falling edges get the same delay. Pulses of one cycle high or low come out intact even when the delay spans many such pulses.
- R6: Code 255 gives a delay of ZERO_STEPS+255 cycles, which uses the last stage of the register.
- R7: With the mode at 1, `main_o` is the logical inverse of the value R3 gives for the same code.
- R8: With the mode at 1 and code c > 0, `pulse_o` rises on the same edge as `ref_o` rises. It stays high for exactly c cycles, even when the input high time was one cycle.
- R9: `pulse_o` stays 0 when the captured code is 0 at the rising edge of `ref_o`. It also stays 0 while the mode is 0.
- R10: A rising edge of `ref_o` while a pulse is still running reloads the width, so the pulse ends c cycles after the last rising edge.
- R11: With the mode at 1 and `main_o` fed back to `sig_i`, the input toggles every ZERO_STEPS+c+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one cycle is one delay step |
| rst | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Signal to be delayed |
| dly_code_i | input | 8 | Step code, 0 to 255 |
| inv_mode_i | input | 1 | 0: follow mode; 1: inverted output plus pulse generation |
| main_o | output | 1 | Input delayed by ZERO_STEPS plus the code, inverted in mode 1 |
| ref_o | output | 1 | Input delayed by ZERO_STEPS only |
| pulse_o | output | 1 | Programmed-width pulse, mode 1 only |

## Verification
Some properties are checked on every cycle. The reference output must track the input at the fixed latency. Code 0 must make the main output equal to the reference in mode 0 and opposite to it in mode 1. Every start of a pulse must coincide with a reference rising edge and must follow a non-zero captured code.

Other behaviour only the bench scenarios can show, by replaying a cycle model. This covers the exact placement of every edge under arbitrary codes, edges held in flight across long delays, the code-255 limit, and exact pulse widths with retriggering. It also covers the oscillator's half period when the output is wired back to the input.

// File: rtl/ptd_pkg.sv
`timescale 1ns/1ps
package ptd_pkg;

    // width of the step code; 2**CODE_W settings
    localparam int unsigned CODE_W = 8;

    typedef enum logic {
        OUT_FOLLOW = 1'b0,
        OUT_INVERT = 1'b1
    } out_mode_e;

    // programming word captured every clock edge
    typedef struct packed {
        out_mode_e          mode;
        logic [CODE_W-1:0]  steps;
    } prog_t;

    // values picked off the delay register
    typedef struct packed {
        logic main_tap;
        logic ref_tap;
        logic pre_ref_tap;
    } taps_t;

    // number of stages needed: every code plus the zero-step part
    function automatic int unsigned chain_len(input int unsigned cw, input int unsigned zero);
        return (32'd1 << cw) + zero;
    endfunction

    // index of the main tap for a given code
    function automatic int unsigned main_index(input int unsigned zero, input logic [CODE_W-1:0] code);
        return zero + int'(code);
    endfunction

endpackage

// File: rtl/ptd_prog_reg.sv
`timescale 1ns/1ps
module ptd_prog_reg
    import ptd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] steps_in,
    input  logic              mode_in,
    output prog_t             active
);

    prog_t next_prog;

    always_comb begin
        next_prog.steps = steps_in;
        next_prog.mode  = mode_in ? OUT_INVERT : OUT_FOLLOW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active.steps <= '0;
            active.mode  <= OUT_FOLLOW;
        end else begin
            active <= next_prog;
        end
    end

endmodule

// File: rtl/ptd_delay_chain.sv
`timescale 1ns/1ps
module ptd_delay_chain #(
    parameter int unsigned DEPTH = 258
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    output logic [DEPTH-1:0] stages
);

    // stage k holds the input sampled k edges before the most recent one
    always_ff @(posedge clk) begin
        if (rst) begin
            stages <= '0;
        end else begin
            stages <= {stages[DEPTH-2:0], shift_in};
        end
    end

endmodule

// File: rtl/ptd_tap_sel.sv
`timescale 1ns/1ps
module ptd_tap_sel
    import ptd_pkg::*;
#(
    parameter int unsigned ZERO_STEPS = 2,
    parameter int unsigned DEPTH      = 258
) (
    input  logic [DEPTH-1:0] stages,
    input  prog_t            prog,
    output taps_t            taps,
    output logic             main_val
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] main_idx;

    always_comb begin
        main_idx = IDX_W'(main_index(ZERO_STEPS, prog.steps));
    end

    // fixed taps for the reference and for its rising-edge look-ahead
    generate
        if (ZERO_STEPS >= 1) begin : g_fixed
            assign taps.ref_tap     = stages[ZERO_STEPS];
            assign taps.pre_ref_tap = stages[ZERO_STEPS-1];
        end else begin : g_bad
            assign taps.ref_tap     = stages[1];
            assign taps.pre_ref_tap = stages[0];
        end
    endgenerate

    assign taps.main_tap = stages[main_idx];

    always_comb begin
        unique case (prog.mode)
            OUT_INVERT: main_val = ~taps.main_tap;
            default:    main_val =  taps.main_tap;
        endcase
    end

endmodule

// File: rtl/ptd_pulse_gen.sv
`timescale 1ns/1ps
module ptd_pulse_gen #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          trig,
    input  logic [CW-1:0] width,
    output logic          pulse
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (!arm) begin
            remain <= '0;
        end else if (trig) begin
            remain <= width;
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign pulse = arm & (remain != '0);

    // R8
    // no_underflow_chk: the count only moves down by one or reloads
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(remain) != '0 && !$past(trig) && $past(arm)) |-> (remain == $past(remain) - CW'(1)));

endmodule

// File: rtl/prog_timing_elem.sv
`timescale 1ns/1ps
module prog_timing_elem
    import ptd_pkg::*;
#(
    parameter int unsigned ZERO_STEPS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sig_i,
    input  logic [CODE_W-1:0] dly_code_i,
    input  logic              inv_mode_i,
    output logic              main_o,
    output logic              ref_o,
    output logic              pulse_o
);

    localparam int unsigned DEPTH = chain_len(CODE_W, ZERO_STEPS);

    prog_t            active;
    logic [DEPTH-1:0] stages;
    taps_t            taps;
    logic             main_val;
    logic             ref_rise_next;
    logic             pulse_val;

    ptd_prog_reg u_prog (
        .clk      (clk),
        .rst      (rst),
        .steps_in (dly_code_i),
        .mode_in  (inv_mode_i),
        .active   (active)
    );

    ptd_delay_chain #(.DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_in (sig_i),
        .stages   (stages)
    );

    ptd_tap_sel #(.ZERO_STEPS(ZERO_STEPS), .DEPTH(DEPTH)) u_taps (
        .stages   (stages),
        .prog     (active),
        .taps     (taps),
        .main_val (main_val)
    );

    // the reference tap rises on the coming edge
    assign ref_rise_next = taps.pre_ref_tap & ~taps.ref_tap;

    ptd_pulse_gen #(.CW(CODE_W)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .arm   (active.mode == OUT_INVERT),
        .trig  (ref_rise_next),
        .width (active.steps),
        .pulse (pulse_val)
    );

    assign main_o  = main_val;
    assign ref_o   = taps.ref_tap;
    assign pulse_o = pulse_val;

    // cycles since reset, for windows that look back at the input
    logic [7:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != '1)  since_rst <= since_rst + 8'd1;
    end

    // R4
    ref_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(since_rst) > ZERO_STEPS + 1) |-> (ref_o == $past(sig_i, ZERO_STEPS + 1)));

    // R3
    zero_code_match_chk: assert property (@(posedge clk) disable iff (rst)
        (active.mode == OUT_FOLLOW && active.steps == '0) |-> (main_o == ref_o));

    // R7
    inv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (active.mode == OUT_INVERT && active.steps == '0) |-> (main_o != ref_o));

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $rose(ref_o));

    // R9
    pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> ($past(active.steps) != '0));

endmodule

// File: tb/tb_prog_timing_elem.sv
`timescale 1ns/1ps
module tb_prog_timing_elem;

    localparam int Z = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig = 1'b0;
    logic       inv = 1'b0;
    logic [7:0] code = 8'd0;
    logic       main_w, ref_w, pulse_w;

    always #2.5 clk = ~clk;

    prog_timing_elem #(.ZERO_STEPS(Z)) dut (
        .clk        (clk),
        .rst        (rst),
        .sig_i      (sig),
        .dly_code_i (code),
        .inv_mode_i (inv),
        .main_o     (main_w),
        .ref_o      (ref_w),
        .pulse_o    (pulse_w)
    );

    typedef struct {
        logic  m;
        logic  r;
        logic  p;
        string tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         fails  = 0;
    bit         hist[0:8191];
    int         n      = 0;
    int         cnt_m  = 0;
    logic [7:0] c_old  = 8'd0;
    logic       m_old  = 1'b0;
    bit         done   = 1'b0;

    function automatic bit hv(input int i);
        if (i < 0) return 1'b0;
        return hist[i];
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: pops one expected item per edge and compares
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "main", main_w, e.m);
            chk(e.tag, "ref R4", ref_w, e.r);
            chk(e.tag, "pulse", pulse_w, e.p);
        end
    end

    // driver: applies one cycle of stimulus and pushes what must follow the next edge
    task automatic step(input logic d, input logic [7:0] c, input logic m,
                        input bit fb, input string tag, output logic dused);
        exp_t e;
        bit   rise;
        @(negedge clk);
        if (fb) d = main_w;
        sig = d; code = c; inv = m;
        dused = d;
        hist[n] = d;
        rise = hv(n - Z) & ~hv(n - 1 - Z);
        if (!m_old)          cnt_m = 0;
        else if (rise)       cnt_m = int'(c_old);
        else if (cnt_m > 0)  cnt_m = cnt_m - 1;
        e.m   = hv(n - Z - int'(c)) ^ m;
        e.r   = hv(n - Z);
        e.p   = m & (cnt_m != 0);
        e.tag = tag;
        q.push_back(e);
        c_old = c; m_old = m;
        n++;
    endtask

    task automatic run(input logic d, input logic [7:0] c, input logic m, input string tag);
        logic du;
        step(d, c, m, 1'b0, tag, du);
    endtask

    initial begin
        logic du;
        int   last_t;
        int   toggles;
        logic prev;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "main", main_w, 1'b0);
        chk("R1", "ref",  ref_w,  1'b0);
        chk("R1", "pulse", pulse_w, 1'b0);
        rst = 1'b0;
        run(1'b0, 8'd0, 1'b0, "R1");

        // R3: follow mode, code 5, irregular pattern
        for (int i = 0; i < 60; i++) run(((i * 7) % 11) > 4, 8'd5, 1'b0, "R3");
        // R3: code 0
        for (int i = 0; i < 30; i++) run(((i * 5) % 7) > 2, 8'd0, 1'b0, "R3");
        // R2: code changes every few cycles
        for (int i = 0; i < 60; i++) run(((i * 3) % 5) > 1, 8'(5 + (i / 6) * 3), 1'b0, "R2");
        // R5: one-cycle pulses with a long delay
        for (int i = 0; i < 80; i++) run((i % 2) == 1 || (i % 9) == 0, 8'd20, 1'b0, "R5");
        // R6: longest delay
        for (int i = 0; i < 320; i++) run(((i * 13) % 17) > 8, 8'd255, 1'b0, "R6");
        // R7: inverted output, code 9
        for (int i = 0; i < 60; i++) run(((i * 7) % 10) > 5, 8'd9, 1'b1, "R7");
        // R8: one-cycle trigger, width 7
        for (int i = 0; i < 280; i++) run(1'b0, 8'd7, 1'b1, "R8");
        run(1'b1, 8'd7, 1'b1, "R8");
        for (int i = 0; i < 20; i++) run(1'b0, 8'd7, 1'b1, "R8");
        // R9: code 0 gives no pulse
        run(1'b1, 8'd0, 1'b1, "R9");
        for (int i = 0; i < 10; i++) run(1'b0, 8'd0, 1'b1, "R9");
        // R9: follow mode gives no pulse
        run(1'b1, 8'd7, 1'b0, "R9");
        for (int i = 0; i < 15; i++) run(1'b0, 8'd7, 1'b0, "R9");
        // R10: retrigger inside a running pulse
        for (int i = 0; i < 10; i++) run(1'b0, 8'd10, 1'b1, "R10");
        for (int i = 0; i < 30; i++) run((i == 0) || (i == 4) || (i == 7), 8'd10, 1'b1, "R10");
        // R11: oscillator, code 3; flush first
        for (int i = 0; i < 270; i++) run(1'b0, 8'd3, 1'b1, "R11");
        prev = 1'b0; last_t = -1; toggles = 0;
        for (int i = 0; i < 60; i++) begin
            step(1'b0, 8'd3, 1'b1, 1'b1, "R11", du);
            if (du !== prev) begin
                if (toggles >= 1) chk("R11", "half period", 1'b1, (i - last_t) == (Z + 3 + 1));
                if (toggles >= 1 && (i - last_t) != (Z + 3 + 1))
                    $display("  R11 interval actual=%0d expected=%0d", i - last_t, Z + 4);
                toggles++;
                last_t = i;
            end
            prev = du;
        end
        chk("R11", "toggle count", 1'b1, toggles >= 8);
        run(1'b0, 8'd3, 1'b1, "R11");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule